// File: doc/BRIEF.md
# Periodic Random Line Eviction Engine

This block sits beside a set-associative last-level cache and disturbs conflict-based timing observation by throwing out lines at random. It counts demand accesses. Each time the count reaches a programmable period, it schedules a programmable burst of eviction targets. Each target gets its own pseudo-random set and way, drawn from a free-running maximal-length shift register.

For each target the engine first asks the cache for the line's state through a query/response handshake. A line that is present and modified is sent out with a write-back-then-invalidate command. A line that is present and clean gets an invalidate-only command. A line that is not present produces no command, but it still uses up one of the burst's targets. Demand accesses keep being counted while a burst is in progress. Targets from triggers that overlap pile up in a saturating pending counter.

Top module: `rand_evict_engine`

## Requirements
- R1: After reset, `probe_valid_o` and `cmd_valid_o` are low, and they stay low until a trigger occurs.
- R2: With a period f of 1 or more, every f-th access strobe adds the programmed burst count n of targets. With f=5 and n=1, ten strobes give exactly two targets, and four strobes give none.
- R3: A period of zero disables the engine. No strobe produces a target.
- R4: Target indices come from a 32-bit Fibonacci shift register seeded with 1. Each step shifts left and loads bit 0 with s[31]^s[21]^s[1]^s[0]. The set is state[SET_W-1:0] and the way is state[SET_W+WAY_W-1:SET_W], both taken before the step. The register steps once per target.
- R5: A query holds `probe_valid_o`, `probe_set_o` and `probe_way_o` stable until `probe_ready_i`. Each target makes exactly one query, and a response is taken only after its query has been accepted.
- R6: A response of valid and dirty produces a command with `cmd_writeback_o`=1 (write back, then invalidate) for the queried set and way.
- R7: A response of valid and clean produces a command with `cmd_writeback_o`=0 (clear valid only) for the queried set and way.
- R8: A response of invalid produces no command, yet the target still counts toward the burst.
- R9: Access counting goes on while targets are pending. A trigger that arrives during a burst adds its n targets to those still pending.
- R10: The pending count saturates at 2^PEND_W-1.
- R11: A command holds its fields stable until `cmd_ready_i`. A query and a command are never offered together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_strobe_i | input | 1 | One demand access this cycle |
| cfg_period_i | input | PERIOD_W | Accesses per trigger (0 disables) |
| cfg_burst_i | input | BURST_W | Targets per trigger |
| probe_valid_o | output | 1 | Line-state query offered |
| probe_ready_i | input | 1 | Query accepted |
| probe_set_o | output | SET_W | Queried set |
| probe_way_o | output | WAY_W | Queried way |
| rsp_valid_i | input | 1 | Line-state response present |
| rsp_line_valid_i | input | 1 | Queried line is present |
| rsp_line_dirty_i | input | 1 | Queried line is modified |
| cmd_valid_o | output | 1 | Eviction command offered |
| cmd_ready_i | input | 1 | Command accepted |
| cmd_set_o | output | SET_W | Set to evict |
| cmd_way_o | output | WAY_W | Way to evict |
| cmd_writeback_o | output | 1 | 1: write back then invalidate; 0: invalidate only |

## Verification
The hardest state to reach is a pending counter driven into saturation while triggers keep landing. The bench gets there with a period of one and a burst of 200 on two back-to-back strobes. The sequencer takes its first target in the same cycle as the second trigger, so exactly 256 targets are expected. Overlapping bursts are produced by strobing continuously while every query is held unaccepted. The bench then drains the queue and counts the targets. Each target's set and way are compared against a software model of the shift register.

// File: rtl/revict_pkg.sv
package revict_pkg;
   typedef enum logic {
      OP_INVAL = 1'b0,
      OP_WBINV = 1'b1
   } evict_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_QUERY,
      ST_WAIT,
      ST_CMD
   } seq_state_e;
endpackage

// File: rtl/revict_trigger.sv
module revict_trigger #(
   parameter int PERIOD_W = 16,
   parameter int BURST_W  = 8,
   parameter int PEND_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_i,
   input  logic [PERIOD_W-1:0] period_i,
   input  logic [BURST_W-1:0]  burst_i,
   input  logic                take_i,
   output logic                fire_o,
   output logic                pend_nz_o
);
   localparam int SUM_W = ((PEND_W > BURST_W) ? PEND_W : BURST_W) + 1;
   localparam logic [PEND_W-1:0] PEND_MAX = '1;

   if (PERIOD_W < 1 || BURST_W < 1 || PEND_W < 1) begin : g_bad_width
      $error("revict_trigger: widths must be positive");
   end

   logic [PERIOD_W-1:0] acc_cnt_q;
   logic [PEND_W-1:0]   pend_q;
   logic [SUM_W-1:0]    pend_sum;
   logic                period_on;
   logic                at_limit;

   assign period_on = (period_i != '0);
   assign at_limit  = (acc_cnt_q >= (period_i - 1'b1));
   assign fire_o    = acc_i && period_on && at_limit;
   assign pend_nz_o = (pend_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_cnt_q <= '0;
      end else if (!period_on) begin
         acc_cnt_q <= '0;
      end else if (acc_i) begin
         acc_cnt_q <= at_limit ? '0 : acc_cnt_q + 1'b1;
      end
   end

   always_comb begin
      pend_sum = SUM_W'(pend_q) + (fire_o ? SUM_W'(burst_i) : '0) - SUM_W'(take_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (pend_sum > SUM_W'(PEND_MAX)) begin
         pend_q <= PEND_MAX;
      end else begin
         pend_q <= pend_sum[PEND_W-1:0];
      end
   end

   // pending only ever falls by the single target taken that cycle
   assert_pend_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q < $past(pend_q)) |-> (pend_q == $past(pend_q) - 1'b1));

   assert_pend_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == PEND_MAX && !take_i) |=> (pend_q == PEND_MAX));

   assert_take_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> pend_nz_o);
endmodule

// File: rtl/revict_lfsr.sv
module revict_lfsr #(
   parameter int          LFSR_W = 32,
   parameter logic [63:0] SEED   = 64'h1,
   parameter int          SET_W  = 10,
   parameter int          WAY_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   output logic [SET_W-1:0] set_o,
   output logic [WAY_W-1:0] way_o
);
   localparam logic [LFSR_W-1:0] SEED_W = SEED[LFSR_W-1:0];

   if (SET_W + WAY_W > LFSR_W) begin : g_bad_fit
      $error("revict_lfsr: index bits exceed register width");
   end
   if (SEED_W == '0) begin : g_bad_seed
      $error("revict_lfsr: seed must be nonzero");
   end

   logic [LFSR_W-1:0] state_q;
   logic              fb;

   if (LFSR_W == 32) begin : g_taps32
      assign fb = state_q[31] ^ state_q[21] ^ state_q[1] ^ state_q[0];
   end else if (LFSR_W == 16) begin : g_taps16
      assign fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
   end else begin : g_taps_bad
      assign fb = 1'b0;
      $error("revict_lfsr: only 16 or 32 bit registers supported");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEED_W;
      end else if (step_i) begin
         state_q <= {state_q[LFSR_W-2:0], fb};
      end
   end

   assign set_o = state_q[SET_W-1:0];
   assign way_o = state_q[SET_W +: WAY_W];

   assert_lfsr_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);

   assert_lfsr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(state_q));
endmodule

// File: rtl/revict_seq.sv
module revict_seq
   import revict_pkg::*;
#(
   parameter int SET_W = 10,
   parameter int WAY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pend_nz_i,
   input  logic [SET_W-1:0] rnd_set_i,
   input  logic [WAY_W-1:0] rnd_way_i,
   output logic             take_o,
   output logic             probe_valid_o,
   input  logic             probe_ready_i,
   input  logic             rsp_valid_i,
   input  logic             rsp_line_valid_i,
   input  logic             rsp_line_dirty_i,
   output logic             cmd_valid_o,
   input  logic             cmd_ready_i,
   output logic [SET_W-1:0] tgt_set_o,
   output logic [WAY_W-1:0] tgt_way_o,
   output evict_op_e        cmd_op_o
);
   seq_state_e state_q;

   assign take_o        = (state_q == ST_IDLE) && pend_nz_i;
   assign probe_valid_o = (state_q == ST_QUERY);
   assign cmd_valid_o   = (state_q == ST_CMD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         tgt_set_o <= '0;
         tgt_way_o <= '0;
         cmd_op_o  <= OP_INVAL;
      end else begin
         unique case (state_q)
            ST_IDLE: if (pend_nz_i) begin
               tgt_set_o <= rnd_set_i;
               tgt_way_o <= rnd_way_i;
               state_q   <= ST_QUERY;
            end
            ST_QUERY: if (probe_ready_i) state_q <= ST_WAIT;
            ST_WAIT: if (rsp_valid_i) begin
               if (rsp_line_valid_i) begin
                  cmd_op_o <= rsp_line_dirty_i ? OP_WBINV : OP_INVAL;
                  state_q  <= ST_CMD;
               end else begin
                  state_q  <= ST_IDLE;
               end
            end
            ST_CMD: if (cmd_ready_i) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_probe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_valid_o && !probe_ready_i) |=> (probe_valid_o && $stable(tgt_set_o) && $stable(tgt_way_o)));

   assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(tgt_set_o) && $stable(tgt_way_o) && $stable(cmd_op_o)));

   assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(probe_valid_o && cmd_valid_o));

   assert_cmd_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid_o) |-> $past(rsp_valid_i && rsp_line_valid_i));

   assert_cmd_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid_o) |-> ((cmd_op_o == OP_WBINV) == $past(rsp_line_dirty_i)));
endmodule

// File: rtl/rand_evict_engine.sv
module rand_evict_engine
   import revict_pkg::*;
#(
   parameter int          SET_W    = 10,
   parameter int          WAY_W    = 4,
   parameter int          PERIOD_W = 16,
   parameter int          BURST_W  = 8,
   parameter int          PEND_W   = 8,
   parameter int          LFSR_W   = 32,
   parameter logic [63:0] SEED     = 64'h1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_strobe_i,
   input  logic [PERIOD_W-1:0] cfg_period_i,
   input  logic [BURST_W-1:0]  cfg_burst_i,
   output logic                probe_valid_o,
   input  logic                probe_ready_i,
   output logic [SET_W-1:0]    probe_set_o,
   output logic [WAY_W-1:0]    probe_way_o,
   input  logic                rsp_valid_i,
   input  logic                rsp_line_valid_i,
   input  logic                rsp_line_dirty_i,
   output logic                cmd_valid_o,
   input  logic                cmd_ready_i,
   output logic [SET_W-1:0]    cmd_set_o,
   output logic [WAY_W-1:0]    cmd_way_o,
   output logic                cmd_writeback_o
);
   if (SET_W < 1 || WAY_W < 1) begin : g_bad_geom
      $error("rand_evict_engine: set and way widths must be positive");
   end

   logic             fire;
   logic             pend_nz;
   logic             take;
   logic [SET_W-1:0] rnd_set;
   logic [WAY_W-1:0] rnd_way;
   logic [SET_W-1:0] tgt_set;
   logic [WAY_W-1:0] tgt_way;
   evict_op_e        cmd_op;

   revict_trigger #(
      .PERIOD_W(PERIOD_W), .BURST_W(BURST_W), .PEND_W(PEND_W)
   ) u_trigger (
      .clk(clk), .rst_n(rst_n), .acc_i(acc_strobe_i),
      .period_i(cfg_period_i), .burst_i(cfg_burst_i),
      .take_i(take), .fire_o(fire), .pend_nz_o(pend_nz)
   );

   revict_lfsr #(
      .LFSR_W(LFSR_W), .SEED(SEED), .SET_W(SET_W), .WAY_W(WAY_W)
   ) u_lfsr (
      .clk(clk), .rst_n(rst_n), .step_i(take),
      .set_o(rnd_set), .way_o(rnd_way)
   );

   revict_seq #(
      .SET_W(SET_W), .WAY_W(WAY_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .pend_nz_i(pend_nz),
      .rnd_set_i(rnd_set), .rnd_way_i(rnd_way), .take_o(take),
      .probe_valid_o(probe_valid_o), .probe_ready_i(probe_ready_i),
      .rsp_valid_i(rsp_valid_i), .rsp_line_valid_i(rsp_line_valid_i),
      .rsp_line_dirty_i(rsp_line_dirty_i),
      .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
      .tgt_set_o(tgt_set), .tgt_way_o(tgt_way), .cmd_op_o(cmd_op)
   );

   assign probe_set_o     = tgt_set;
   assign probe_way_o     = tgt_way;
   assign cmd_set_o       = tgt_set;
   assign cmd_way_o       = tgt_way;
   assign cmd_writeback_o = (cmd_op == OP_WBINV);

   // an idle engine with period zero never gains work
   assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_period_i == '0 && !pend_nz) |=> !pend_nz);

   assert_fire_work_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cfg_burst_i != '0) |=> pend_nz);
endmodule

// File: tb/tb_rand_evict_engine.sv
module tb_rand_evict_engine;
   localparam int SET_W = 10;
   localparam int WAY_W = 4;

   typedef struct packed {
      logic [15:0] f;
      logic [7:0]  n;
      logic [15:0] acc;
      logic        lv;
      logic        ld;
      logic [15:0] exp;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VEC [0:NV-1] = '{
      '{16'd5, 8'd1, 16'd10, 1'b1, 1'b1, 16'd2},
      '{16'd5, 8'd1, 16'd5,  1'b1, 1'b0, 16'd1},
      '{16'd3, 8'd2, 16'd6,  1'b0, 1'b0, 16'd4},
      '{16'd2, 8'd3, 16'd4,  1'b1, 1'b1, 16'd6},
      '{16'd0, 8'd4, 16'd10, 1'b1, 1'b1, 16'd0},
      '{16'd1, 8'd1, 16'd3,  1'b1, 1'b0, 16'd3},
      '{16'd7, 8'd2, 16'd20, 1'b1, 1'b1, 16'd4}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc = 1'b0;
   logic [15:0] period = '0;
   logic [7:0]  burst = '0;
   logic probe_valid, probe_ready = 1'b0;
   logic [SET_W-1:0] probe_set, cmd_set;
   logic [WAY_W-1:0] probe_way, cmd_way;
   logic rsp_valid = 1'b0, rsp_lv = 1'b0, rsp_ld = 1'b0;
   logic cmd_valid, cmd_ready = 1'b0, cmd_wb;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   logic [31:0] model;

   always #5 clk = ~clk;

   rand_evict_engine dut (
      .clk(clk), .rst_n(rst_n), .acc_strobe_i(acc),
      .cfg_period_i(period), .cfg_burst_i(burst),
      .probe_valid_o(probe_valid), .probe_ready_i(probe_ready),
      .probe_set_o(probe_set), .probe_way_o(probe_way),
      .rsp_valid_i(rsp_valid), .rsp_line_valid_i(rsp_lv), .rsp_line_dirty_i(rsp_ld),
      .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
      .cmd_set_o(cmd_set), .cmd_way_o(cmd_way), .cmd_writeback_o(cmd_wb)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic logic [31:0] lfsr_next(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; acc = 1'b0; probe_ready = 1'b0;
      rsp_valid = 1'b0; cmd_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model = 32'h1;
   endtask

   task automatic strobe(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         acc = 1'b1;
      end
      @(negedge clk);
      acc = 1'b0;
   endtask

   // serve one target; found=0 when no query appears in the window
   task automatic serve(input bit lv, input bit ld, output bit found);
      int w = 0;
      found = 0;
      while (!probe_valid && w < 50) begin
         @(negedge clk);
         w++;
      end
      if (!probe_valid) return;
      found = 1;
      // R4: indices follow the shift-register model
      check(probe_set == model[SET_W-1:0], "R4 set", probe_set, model[SET_W-1:0]);
      check(probe_way == model[SET_W +: WAY_W], "R4 way", probe_way, model[SET_W +: WAY_W]);
      model = lfsr_next(model);
      @(negedge clk);
      // R5: query stays up while not accepted
      check(probe_valid == 1'b1, "R5 hold", probe_valid, 1);
      probe_ready = 1'b1;
      @(negedge clk);
      probe_ready = 1'b0;
      rsp_valid = 1'b1; rsp_lv = lv; rsp_ld = ld;
      @(negedge clk);
      rsp_valid = 1'b0;
      if (lv) begin
         check(cmd_valid == 1'b1, ld ? "R6 cmd" : "R7 cmd", cmd_valid, 1);
         check(cmd_wb == ld, ld ? "R6 op" : "R7 op", cmd_wb, ld);
         check(probe_valid == 1'b0, "R11 excl", probe_valid, 0);
         @(negedge clk);
         check(cmd_valid && cmd_set == probe_set && cmd_way == probe_way, "R11 hold", cmd_valid, 1);
         cmd_ready = 1'b1;
         @(negedge clk);
         cmd_ready = 1'b0;
      end else begin
         for (int i = 0; i < 3; i++) begin
            check(cmd_valid == 1'b0, "R8 no cmd", cmd_valid, 0);
            @(negedge clk);
         end
      end
   endtask

   task automatic drain(input bit lv, input bit ld, input int expn, input string req);
      int got = 0;
      bit f = 1;
      while (f) begin
         serve(lv, ld, f);
         if (f) got++;
      end
      check(got == expn, req, got, expn);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: quiet after reset
      @(negedge clk);
      check(probe_valid == 1'b0, "R1 probe", probe_valid, 0);
      check(cmd_valid == 1'b0, "R1 cmd", cmd_valid, 0);

      for (int v = 0; v < NV; v++) begin
         do_reset();
         period = VEC[v].f;
         burst = VEC[v].n;
         strobe(int'(VEC[v].acc));
         drain(VEC[v].lv, VEC[v].ld, int'(VEC[v].exp),
               (VEC[v].f == 0) ? "R3 count" : (VEC[v].lv ? "R2/R9 count" : "R8 count"));
      end

      // R2: four strobes short of the period produce nothing
      do_reset();
      period = 16'd5; burst = 8'd1;
      strobe(4);
      repeat (10) @(negedge clk);
      check(probe_valid == 1'b0, "R2 early", probe_valid, 0);
      strobe(1);
      drain(1'b1, 1'b0, 1, "R2 fifth");

      // R9: counting continues while a query waits unaccepted
      do_reset();
      period = 16'd3; burst = 8'd1;
      strobe(9);
      drain(1'b1, 1'b1, 3, "R9 overlap");

      // R10: saturation of pending targets
      do_reset();
      period = 16'd1; burst = 8'd200;
      strobe(2);
      burst = 8'd0;
      drain(1'b0, 1'b0, 256, "R10 saturate");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule